// File: doc/BRIEF.md
# Shared-Timebase Conversion Pacer

This block paces a bank of analog-to-digital converters from a single timebase. A programmable period count sets how many clocks separate two conversion starts. Each time the period elapses, the block raises a one-clock start strobe on every channel whose enable bit is set. All enabled channels are started in the same clock, so the samples taken in one period line up in time.

The period can never be shorter than the converter floor, which is a parameter set in clocks. A count of zero, or any count below the floor, runs the converters at their fastest rate, one start per floor period. Writing a new count restarts the period, so the first start after a write falls one full new period after it. The conversion-busy input suppresses a start that would land while the converters are still busy. A channel mask can be changed at any time. Only the mask value present at the shared period boundary takes effect, so a newly enabled channel joins at the next common start.

Top module: `convTimer`

## Requirements
- R1: Out of reset every strobe is low, the stored count is zero, and the first strobe on the enabled channels is visible after the MIN_CYCLES-th active clock edge that follows reset release.
- R2: With a stored count C of at least MIN_CYCLES, strobes recur exactly every C clocks.
- R3: With a stored count from 1 to MIN_CYCLES-1, strobes recur every MIN_CYCLES clocks, never faster.
- R4: A stored count of zero selects the maximum rate of one strobe every MIN_CYCLES clocks.
- R5: A write (cntWrEn high at an edge) loads all CNT_W bits at once and restarts the period. The first strobe after the write is visible exactly max(C, MIN_CYCLES) clocks after the write edge, whatever the phase was. A period end that falls on the write edge produces no strobe.
- R6: At a period end, convStrobe equals chanEnable bit for bit (bit i is channel i), with all enabled channels set in the same cycle.
- R7: A channel whose enable bit is 0 at the period end gets no strobe, and an all-zero mask produces no strobe at all.
- R8: A channel enabled partway through a period gets its first strobe at the next shared period end, never earlier.
- R9: If convBusy is high in the cycle a period ends, that start is dropped on every channel and the following period keeps its normal timing.
- R10: Each strobe lasts exactly one clock cycle.
- R11: Counts above 8 bits are used in full and are not truncated (for example a count of 300 gives a 300-clock period).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntWrEn | input | 1 | Full-width write strobe for the period count |
| cntWrData | input | CNT_W (32) | New period count in clocks |
| chanEnable | input | NCH (16) | Continuous-conversion enable per channel |
| convBusy | input | 1 | Converters still busy; blocks a start |
| convStrobe | output | NCH (16) | One-clock conversion start per channel |

## Verification
The period logic is driven with counts of zero, counts below the floor, a count equal to the floor, counts above it and a count wider than eight bits. The spacing between strobes is what separates clamping, free-running and plain counting. Rewrites in the middle of a period show whether the phase restarts or carries on. Single-bit, sparse and empty masks, together with mask changes between period ends, show whether all channels move in lockstep and a late enable waits for the shared tick. A busy level held over a period end checks that the start is dropped, and random count and mask pairs check the period arithmetic at many points.

// File: rtl/convTimerPkg.sv
package convTimerPkg;
  // Per-cycle commands from the control module to the datapath
  typedef struct packed {
    logic loadPeriod;    // capture a new count
    logic restartPhase;  // return phase counter to zero
    logic fire;          // launch a strobe on enabled channels
  } ctlStrobes_t;
endpackage

// File: rtl/convTimerCtrl.sv
module convTimerCtrl
  import convTimerPkg::*;
(
  input  logic        cntWrEn,
  input  logic        periodEnd,
  input  logic        convBusy,
  output ctlStrobes_t ctl
);
  // A write always wins over a coinciding period end, and a busy
  // converter swallows the start without disturbing the timebase.
  always_comb begin
    ctl.loadPeriod   = cntWrEn;
    ctl.restartPhase = cntWrEn | periodEnd;
    ctl.fire         = periodEnd & ~cntWrEn & ~convBusy;
  end
endmodule

// File: rtl/convTimerPath.sv
module convTimerPath
  import convTimerPkg::*;
#(
  parameter int NCH        = 16,
  parameter int CNT_W      = 32,
  parameter int MIN_CYCLES = 250
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      ctl,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic [NCH-1:0]   chanEnable,
  output logic             periodEnd,
  output logic [NCH-1:0]   convStrobe
);
  localparam logic [CNT_W-1:0] FloorCnt = CNT_W'(MIN_CYCLES);
  localparam logic [CNT_W-1:0] OneCnt   = CNT_W'(1);

  logic [CNT_W-1:0] periodReg;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] effPeriod;

  // Clamp: zero and short counts both fall back to the conversion floor
  always_comb begin
    effPeriod = (periodReg < FloorCnt) ? FloorCnt : periodReg;
    periodEnd = (phaseCnt == effPeriod - OneCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodReg <= '0;
      phaseCnt  <= '0;
    end else begin
      if (ctl.loadPeriod) periodReg <= cntWrData;
      if (ctl.restartPhase) phaseCnt <= '0;
      else                  phaseCnt <= phaseCnt + OneCnt;
    end
  end

  // One strobe flop per channel, all fed by the same fire command
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) convStrobe[ch] <= 1'b0;
      else       convStrobe[ch] <= ctl.fire & chanEnable[ch];
    end
  end
endmodule

// File: rtl/convTimer.sv
module convTimer
  import convTimerPkg::*;
#(
  parameter int NCH        = 16,
  parameter int CNT_W      = 32,
  parameter int MIN_CYCLES = 250
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic [NCH-1:0]   chanEnable,
  input  logic             convBusy,
  output logic [NCH-1:0]   convStrobe
);
  ctlStrobes_t ctl;
  logic        periodEnd;

  convTimerCtrl u_ctrl (
    .cntWrEn   (cntWrEn),
    .periodEnd (periodEnd),
    .convBusy  (convBusy),
    .ctl       (ctl)
  );

  convTimerPath #(
    .NCH        (NCH),
    .CNT_W      (CNT_W),
    .MIN_CYCLES (MIN_CYCLES)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cntWrData  (cntWrData),
    .chanEnable (chanEnable),
    .periodEnd  (periodEnd),
    .convStrobe (convStrobe)
  );
endmodule

// File: rtl/convTimerChecker.sv
module convTimerChecker #(
  parameter int NCH        = 16,
  parameter int CNT_W      = 32,
  parameter int MIN_CYCLES = 250
) (
  input logic           clk,
  input logic           rstN,
  input logic           cntWrEn,
  input logic [NCH-1:0] chanEnable,
  input logic           convBusy,
  input logic [NCH-1:0] convStrobe
);
  localparam logic [CNT_W-1:0] FloorCnt = CNT_W'(MIN_CYCLES);

  // Cycles since the last write or visible strobe, saturating
  logic [CNT_W-1:0] gapCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                             gapCnt <= CNT_W'(1);
    else if (cntWrEn || (convStrobe != '0)) gapCnt <= CNT_W'(1);
    else if (gapCnt != '1)                 gapCnt <= gapCnt + CNT_W'(1);
  end

  // R6: a strobe carries exactly the mask seen at the period end
  p_lockstep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (convStrobe != '0) |-> (convStrobe == $past(chanEnable)));

  // R7: no strobe on a channel that was disabled
  p_masked_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((convStrobe & ~$past(chanEnable)) == '0));

  // R9: busy at the period end drops the start
  p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(convBusy) |-> (convStrobe == '0));

  // R5: a write edge never yields a strobe in the next cycle
  p_write_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(cntWrEn) |-> (convStrobe == '0));

  // R3: strobes never come closer together than the floor
  p_floor_r3: assert property (@(posedge clk) disable iff (!rstN)
    (convStrobe != '0) |-> (gapCnt >= FloorCnt));

  // R10: strobes are single-cycle
  p_one_wide_r10: assert property (@(posedge clk) disable iff (!rstN)
    (convStrobe != '0) |=> (convStrobe == '0));
endmodule

bind convTimer convTimerChecker #(
  .NCH        (NCH),
  .CNT_W      (CNT_W),
  .MIN_CYCLES (MIN_CYCLES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cntWrEn    (cntWrEn),
  .chanEnable (chanEnable),
  .convBusy   (convBusy),
  .convStrobe (convStrobe)
);

// File: tb/tb_convTimer.sv
module tb_convTimer;
  localparam int NCH   = 16;
  localparam int CNT_W = 32;
  localparam int MINC  = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cntWrEn = 1'b0;
  logic [CNT_W-1:0] cntWrData = '0;
  logic [NCH-1:0]   chanEnable = '0;
  logic             convBusy = 1'b0;
  logic [NCH-1:0]   convStrobe;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  convTimer #(.NCH(NCH), .CNT_W(CNT_W), .MIN_CYCLES(MINC)) dut (
    .clk(clk), .rstN(rstN), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .chanEnable(chanEnable), .convBusy(convBusy), .convStrobe(convStrobe)
  );

  function automatic int effOf(input longint c);
    return (c < MINC) ? MINC : int'(c);
  endfunction

  task automatic check(input string tag, input logic [NCH-1:0] act,
                       input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a negedge; leaves us at the negedge after the write edge
  task automatic writeCount(input logic [CNT_W-1:0] c);
    cntWrData = c;
    cntWrEn   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cntWrEn   = 1'b0;
  endtask

  // Observe one period; strobe expected after the eff-th edge
  task automatic runPeriod(input int eff, input logic [NCH-1:0] expMask,
                           input string tag, input int chgAt,
                           input logic [NCH-1:0] chgMask, input bit busyTick);
    logic [NCH-1:0] early;
    early = '0;
    for (int k = 1; k <= eff; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k < eff) early |= convStrobe;
      else         check(tag, convStrobe, expMask);
      if (k == chgAt) chanEnable = chgMask;
      if (busyTick && k == eff - 1) convBusy = 1'b1;
      if (k == eff) convBusy = 1'b0;
    end
    check("R10 quiet between strobes", early, '0);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: got %0d cycles expected < 150000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    chanEnable = 16'hFFFF;
    repeat (4) @(negedge clk);
    check("R1 reset strobes low", convStrobe, '0);
    rstN = 1'b1;
    // R1: count 0 after reset -> floor period
    runPeriod(MINC, 16'hFFFF, "R1 first strobe", 0, '0, 0);

    writeCount(20);
    runPeriod(20, 16'hFFFF, "R2 period 20", 0, '0, 0);
    runPeriod(20, 16'hFFFF, "R2 period 20 repeat", 0, '0, 0);

    writeCount(0);
    runPeriod(MINC, 16'hFFFF, "R4 zero count", 0, '0, 0);
    runPeriod(MINC, 16'hFFFF, "R4 zero count repeat", 0, '0, 0);

    writeCount(3);
    runPeriod(MINC, 16'hFFFF, "R3 count 3 clamped", 0, '0, 0);
    writeCount(MINC - 1);
    runPeriod(MINC, 16'hFFFF, "R3 count floor-1 clamped", 0, '0, 0);
    writeCount(MINC);
    runPeriod(MINC, 16'hFFFF, "R2 count at floor", 0, '0, 0);
    writeCount(MINC + 1);
    runPeriod(MINC + 1, 16'hFFFF, "R2 count floor+1", 0, '0, 0);

    writeCount(300);
    runPeriod(300, 16'hFFFF, "R11 wide count 300", 0, '0, 0);

    // R5: rewrite mid-period
    writeCount(25);
    repeat (7) @(negedge clk);
    writeCount(15);
    runPeriod(15, 16'hFFFF, "R5 restart after rewrite", 0, '0, 0);
    runPeriod(15, 16'hFFFF, "R5 steady after rewrite", 0, '0, 0);

    // R6/R7 mask patterns
    writeCount(12);
    chanEnable = 16'h0001;
    runPeriod(12, 16'h0001, "R6 mask 0001", 0, '0, 0);
    chanEnable = 16'h8000;
    runPeriod(12, 16'h8000, "R6 mask 8000", 0, '0, 0);
    chanEnable = 16'hA5A5;
    runPeriod(12, 16'hA5A5, "R6 mask A5A5", 0, '0, 0);
    chanEnable = 16'h0000;
    runPeriod(12, 16'h0000, "R7 empty mask", 0, '0, 0);

    // R8: enable partway through a period
    chanEnable = 16'h00F0;
    runPeriod(12, 16'h00F0, "R8 before change", 0, '0, 0);
    runPeriod(12, 16'h0F0F, "R8 late enable joins shared tick", 5, 16'h0F0F, 0);
    runPeriod(12, 16'h0000, "R7 disabled mid-period", 4, 16'h0000, 0);
    chanEnable = 16'hFFFF;

    // R9: busy at the period end
    runPeriod(12, 16'hFFFF, "R9 before busy", 0, '0, 0);
    runPeriod(12, 16'h0000, "R9 busy drops start", 0, '0, 1);
    runPeriod(12, 16'hFFFF, "R9 timing kept after busy", 0, '0, 0);

    // Random counts and masks
    for (int i = 0; i < 20; i++) begin
      logic [CNT_W-1:0] c;
      logic [NCH-1:0]   m;
      c = CNT_W'($urandom_range(0, 40));
      m = NCH'($urandom);
      chanEnable = m;
      writeCount(c);
      runPeriod(effOf(longint'(c)), m, "R2 random", 0, '0, 0);
      runPeriod(effOf(longint'(c)), m, "R6 random repeat", 0, '0, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule